// File: doc/BRIEF.md
# LCD Segment Scan and Drive Sequencer

This block is the refresh side of a column driver for a dot-matrix liquid-crystal panel with 64 columns. It tracks the panel line now being scanned in a 6-bit line counter. The counter is loaded from a start-line value while the frame sync input is high, which gives vertical scrolling in hardware. It advances on each falling edge of the line clock. After every update of the counter, a small state machine reads the 64 bytes of the matching page out of display memory through a synchronous read port. From each byte it keeps the one bit that belongs to the current line, and it builds a 64-bit shadow row from those bits.

On the rising edge of the line clock, the shadow row is copied into the segment latch and the display-enable request is sampled. Each column then gets a 2-bit drive-level code. The code depends on its pixel bit, the AC alternation phase and the sampled display-enable state. A strap input picks normal or mirrored column order. All inputs are synchronous to `clk`. The line clock is slow: each of its high and low phases lasts at least 70 `clk` cycles.

Fetch states: `F_IDLE` waits for a counter update. The transition `start` (counter update) enters `F_READ`, which issues one read per cycle for columns 0 to 63. The transition `last_col` leads to `F_LAST`, which captures the final byte. The transition `done` returns to `F_IDLE`. An update seen in any state restarts the fetch at column 0 in `F_READ`.

Top module: `lcd_seg_scan`

## Requirements
- R1: While `frame_sync` is high, the line counter is loaded with `start_line`. This load takes priority over a line clock fall in the same cycle.
- R2: When `frame_sync` is low, each falling edge of `line_clk` advances the line counter by one. The counter wraps from 63 to 0.
- R3: On each rising edge of `line_clk`, the segment latch takes the row for line Z. Column y of that row is bit Z[2:0] of the byte at RAM address Z[5:3]*64 + y.
- R4: With the display enabled, the drive code for a pixel bit of 1 is 2'b00 (V0) when `alt_phase`=0 and 2'b11 (V5) when `alt_phase`=1. For a pixel bit of 0 it is 2'b01 (V2) and 2'b10 (V3) in the same two phases. Segment s occupies `seg_lvl[2s+1:2s]`, with s = 0 for segment 1.
- R5: With the display disabled, every segment carries the non-select code for the current phase (2'b01 when `alt_phase`=0, 2'b10 when `alt_phase`=1), whatever the RAM holds.
- R6: A change of `disp_on` takes effect only at the next rising edge of `line_clk`.
- R7: With `dir_sel`=1, segment s shows column address y = s. With `dir_sel`=0, it shows y = 63 - s.
- R8: While `rst_n` is low, every segment carries the non-select code for the current phase. Reset leaves the counter at 0, the latch cleared and the display disabled.
- R9: After each counter update, the block makes exactly 64 reads, one per cycle, at addresses Z[5:3]*64 + 0 up to Z[5:3]*64 + 63 in ascending order. Data is expected one cycle after `ram_rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_clk | input | 1 | Line clock; falling edge advances the line, rising edge latches the row |
| frame_sync | input | 1 | Frame sync; while high, loads the start line |
| alt_phase | input | 1 | AC alternation phase |
| disp_on | input | 1 | Display enable request |
| start_line | input | 6 | Line shown at the top of the panel |
| dir_sel | input | 1 | Column order strap (1 normal, 0 mirrored) |
| ram_rd_en | output | 1 | Display RAM read strobe |
| ram_rd_addr | output | 9 | Display RAM read address {page, column} |
| ram_rd_data | input | 8 | Display RAM read data, one cycle after the strobe |
| seg_lvl | output | 128 | Two-bit drive code for each of the 64 segments |

## Verification
A wrong line counter shows up as the wrong page in the read addresses within one cycle of the update. It shows up as the wrong bit plane in `seg_lvl` at the next rising edge of the line clock. A stuck or misordered fetch leaves the read count or the address sequence wrong, and it corrupts individual columns of the next latched row. An enable state sampled at the wrong time shows as select codes appearing or vanishing one line early. Each line is compared as a whole 128-bit vector against a row the bench computes from its own RAM image.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

    typedef enum logic [1:0] {
        LV_V0 = 2'b00,
        LV_V2 = 2'b01,
        LV_V3 = 2'b10,
        LV_V5 = 2'b11
    } drive_lvl_t;

    typedef enum logic [1:0] {
        F_IDLE = 2'b00,
        F_READ = 2'b01,
        F_LAST = 2'b10
    } fetch_st_t;

    function automatic drive_lvl_t drive_code(input logic on, input logic pix, input logic alt);
        drive_lvl_t lv;
        if (on && pix) lv = alt ? LV_V5 : LV_V0;
        else           lv = alt ? LV_V3 : LV_V2;
        return lv;
    endfunction

endpackage

// File: rtl/lcd_zline_ctr.sv
module lcd_zline_ctr #(
    parameter int ZW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_sync,
    input  logic          line_fall,
    input  logic [ZW-1:0] start_line,
    output logic [ZW-1:0] zline,
    output logic          z_upd
);
    logic fs_q;

    always_comb begin
        z_upd = line_fall || (frame_sync && !fs_q) || (frame_sync && (start_line != zline));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            zline <= '0;
            fs_q  <= 1'b0;
        end else begin
            fs_q <= frame_sync;
            if (frame_sync)     zline <= start_line;
            else if (line_fall) zline <= zline + 1'b1;
        end
    end

    AST_Z_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
        frame_sync |=> (zline == $past(start_line))); // R1
    AST_Z_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (line_fall && !frame_sync) |=> (zline == ZW'($past(zline) + 1'b1))); // R2
    AST_Z_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_fall && !frame_sync) |=> $stable(zline)); // R2

endmodule

// File: rtl/lcd_row_fetch.sv
module lcd_row_fetch
    import lcd_scan_pkg::*;
#(
    parameter int COLS = 64,
    parameter int ZW   = 6,
    localparam int CW  = $clog2(COLS),
    localparam int BW  = 3,
    localparam int PW  = ZW - BW,
    localparam int AW  = PW + CW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            kick,
    input  logic [ZW-1:0]   zline,
    output logic            ram_rd_en,
    output logic [AW-1:0]   ram_rd_addr,
    input  logic [7:0]      ram_rd_data,
    output logic [COLS-1:0] row
);
    fetch_st_t     state;
    logic [CW-1:0] col;
    logic          cap_vld;
    logic [CW-1:0] cap_col;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= F_IDLE;
            col   <= '0;
        end else if (kick) begin
            state <= F_READ;
            col   <= '0;
        end else begin
            unique case (state)
                F_IDLE: state <= F_IDLE;
                F_READ: begin
                    col <= col + 1'b1;
                    if (col == CW'(COLS - 1)) state <= F_LAST;
                end
                F_LAST: state <= F_IDLE;
                default: state <= F_IDLE;
            endcase
        end
    end

    always_comb begin
        ram_rd_en   = (state == F_READ);
        ram_rd_addr = {zline[ZW-1:BW], col};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_vld <= 1'b0;
            cap_col <= '0;
            row     <= '0;
        end else begin
            cap_vld <= ram_rd_en;
            cap_col <= col;
            if (cap_vld) row[cap_col] <= ram_rd_data[zline[BW-1:0]];
        end
    end

    AST_FETCH_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_rd_en && !kick && (col != CW'(COLS - 1))) |=> (ram_rd_en && col == CW'($past(col) + 1'b1))); // R9

endmodule

// File: rtl/lcd_seg_level.sv
module lcd_seg_level
    import lcd_scan_pkg::*;
#(
    parameter int COLS = 64
) (
    input  logic              on,
    input  logic              alt,
    input  logic              dir,
    input  logic [COLS-1:0]   row,
    output logic [2*COLS-1:0] seg_lvl
);
    for (genvar s = 0; s < COLS; s++) begin : g_seg
        logic pix;
        always_comb begin
            pix = dir ? row[s] : row[COLS-1-s];
            seg_lvl[2*s +: 2] = drive_code(on, pix, alt);
        end
    end

endmodule

// File: rtl/lcd_seg_scan.sv
module lcd_seg_scan #(
    parameter int COLS = 64,
    parameter int ZW   = 6,
    localparam int AW  = ZW - 3 + $clog2(COLS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_clk,
    input  logic              frame_sync,
    input  logic              alt_phase,
    input  logic              disp_on,
    input  logic [ZW-1:0]     start_line,
    input  logic              dir_sel,
    output logic              ram_rd_en,
    output logic [AW-1:0]     ram_rd_addr,
    input  logic [7:0]        ram_rd_data,
    output logic [2*COLS-1:0] seg_lvl
);
    logic            line_q;
    logic            line_rise;
    logic            line_fall;
    logic [ZW-1:0]   zline;
    logic            z_upd;
    logic [COLS-1:0] shadow;
    logic [COLS-1:0] seg_latch;
    logic            on_q;

    always_comb begin
        line_rise = line_clk && !line_q;
        line_fall = !line_clk && line_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q    <= 1'b0;
            seg_latch <= '0;
            on_q      <= 1'b0;
        end else begin
            line_q <= line_clk;
            if (line_rise) begin
                seg_latch <= shadow;
                on_q      <= disp_on;
            end
        end
    end

    lcd_zline_ctr #(.ZW(ZW)) u_zctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_sync (frame_sync),
        .line_fall  (line_fall),
        .start_line (start_line),
        .zline      (zline),
        .z_upd      (z_upd)
    );

    lcd_row_fetch #(.COLS(COLS), .ZW(ZW)) u_fetch (
        .clk         (clk),
        .rst_n       (rst_n),
        .kick        (z_upd),
        .zline       (zline),
        .ram_rd_en   (ram_rd_en),
        .ram_rd_addr (ram_rd_addr),
        .ram_rd_data (ram_rd_data),
        .row         (shadow)
    );

    lcd_seg_level #(.COLS(COLS)) u_lvl (
        .on      (on_q),
        .alt     (alt_phase),
        .dir     (dir_sel),
        .row     (seg_latch),
        .seg_lvl (seg_lvl)
    );

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !line_rise |=> $stable(seg_latch)); // R3
    AST_ONOFF_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        !line_rise |=> $stable(on_q)); // R6
    AST_OFF_NONSEL: assert property (@(posedge clk) disable iff (!rst_n)
        !on_q |-> (seg_lvl == {COLS{alt_phase ? 2'b10 : 2'b01}})); // R5

endmodule

// File: tb/tb_lcd_seg_scan.sv
module tb_lcd_seg_scan;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         line_clk = 1'b1;
    logic         frame_sync = 1'b0;
    logic         alt_phase = 1'b0;
    logic         disp_on = 1'b0;
    logic [5:0]   start_line = '0;
    logic         dir_sel = 1'b1;
    logic         ram_rd_en;
    logic [8:0]   ram_rd_addr;
    logic [7:0]   ram_rd_data = '0;
    logic [127:0] seg_lvl;

    logic [7:0] mem [0:511];
    int n_chk = 0;
    int n_fail = 0;
    int rd_cnt = 0;
    int addr_err = 0;
    int exp_page = 0;
    bit done = 0;

    always #10 clk = ~clk;

    lcd_seg_scan dut (
        .clk(clk), .rst_n(rst_n), .line_clk(line_clk), .frame_sync(frame_sync),
        .alt_phase(alt_phase), .disp_on(disp_on), .start_line(start_line),
        .dir_sel(dir_sel), .ram_rd_en(ram_rd_en), .ram_rd_addr(ram_rd_addr),
        .ram_rd_data(ram_rd_data), .seg_lvl(seg_lvl)
    );

    always @(posedge clk) begin
        if (ram_rd_en) begin
            ram_rd_data <= mem[ram_rd_addr];
            if (ram_rd_addr != 9'(exp_page * 64 + (rd_cnt % 64))) addr_err = addr_err + 1;
            rd_cnt = rd_cnt + 1;
        end
    end

    function automatic logic [127:0] exp_seg(input int zl, input bit dir, input bit alt, input bit on);
        logic [127:0] r;
        for (int s = 0; s < 64; s++) begin
            int  y;
            bit  pix;
            y   = dir ? s : 63 - s;
            pix = mem[(zl / 8) * 64 + y][zl % 8];
            if (on && pix) r[2*s +: 2] = alt ? 2'b11 : 2'b00;
            else           r[2*s +: 2] = alt ? 2'b10 : 2'b01;
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [127:0] got, input logic [127:0] expv);
        n_chk++;
        if (got !== expv) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, expv);
        end
    endtask

    // One line period: fall, fetch, rise, then checks of R3/R4/R7/R9 on the latched row.
    task automatic run_line(input int zl, input string req);
        @(negedge clk);
        rd_cnt = 0; addr_err = 0; exp_page = zl / 8;
        line_clk = 1'b0;
        repeat (80) @(negedge clk);
        line_clk = 1'b1;
        repeat (4) @(negedge clk);
        chk("R9 read count/order", 128'(rd_cnt * 1000 + addr_err), 128'(64 * 1000));
        chk(req, seg_lvl, exp_seg(zl, dir_sel, alt_phase, disp_on));
        alt_phase = ~alt_phase;
        #1;
        chk("R4 phase swap", seg_lvl, exp_seg(zl, dir_sel, alt_phase, disp_on));
        repeat (72) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int a = 0; a < 512; a++) mem[a] = 8'((a * 53 + (a >> 3) * 7 + 11) ^ (a >> 2));
        repeat (3) @(negedge clk);
        chk("R8 reset nonselect phase0", seg_lvl, {64{2'b01}});
        alt_phase = 1'b1; #1;
        chk("R8 reset nonselect phase1", seg_lvl, {64{2'b10}});
        alt_phase = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // Frame 1: start line 0, normal order, display off for the first line
        frame_sync = 1'b1;
        repeat (80) @(negedge clk);
        run_line(0, "R1 preset line0 R5 off");
        frame_sync = 1'b0;
        disp_on = 1'b1;
        repeat (10) @(negedge clk);
        chk("R6 enable waits for line clock", seg_lvl, {64{alt_phase ? 2'b10 : 2'b01}});
        for (int z = 1; z < 64; z++) run_line(z, "R3 R4 R7 normal order");
        run_line(0, "R2 wrap 63 to 0");

        // Frame 2: scrolled start, mirrored order
        dir_sel = 1'b0;
        start_line = 6'd60;
        frame_sync = 1'b1;
        repeat (80) @(negedge clk);
        run_line(60, "R1 preset priority over fall");
        frame_sync = 1'b0;
        for (int k = 61; k < 66; k++) run_line(k % 64, "R2 R7 mirrored wrap");

        disp_on = 1'b0;
        repeat (10) @(negedge clk);
        chk("R6 disable waits for line clock", seg_lvl, exp_seg(1, dir_sel, alt_phase, 1'b1));
        run_line(2, "R5 display off");

        dir_sel = 1'b1; #1;
        chk("R5 off any order", seg_lvl, {64{alt_phase ? 2'b10 : 2'b01}});

        disp_on = 1'b1;
        run_line(3, "R7 strap back to normal");
        @(negedge clk); rst_n = 1'b0; #1;
        chk("R8 reset forces nonselect", seg_lvl, {64{alt_phase ? 2'b10 : 2'b01}});

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule